// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block stores a four-bit word and, on each rising clock edge, either keeps it, moves it one place toward the low-order end, moves it one place toward the high-order end, or replaces it with a parallel word. A two-bit operation select picks the action. Each shift direction has its own serial entry bit, so a rightward shift takes its new high-order bit from one pin and a leftward shift takes its new low-order bit from another. All four stored bits are always visible on the output bus.

The operations act as four named states of the selector: KEEP (select 00), DOWN (select 01, rightward), UP (select 10, leftward) and LOAD (select 11). Any operation may follow any other on the next edge; there are no forbidden transitions. An active-low clear, independent of the clock, empties the register and overrides every operation for as long as it is held. Rotation is made outside the block by wiring the low-order output back to the right-shift entry pin.

Top module: `ushift4`

## Requirements
- R1: With select 00 (KEEP) a rising edge leaves `q` unchanged.
- R2: With select 01 (DOWN) a rising edge makes `q` equal to {`ser_right_in`, old `q[3:1]`}; old `q[0]` is lost.
- R3: With select 10 (UP) a rising edge makes `q` equal to {old `q[2:0]`, `ser_left_in`}; old `q[3]` is lost.
- R4: With select 11 (LOAD) a rising edge copies `par_in` into `q`, bit 3 (high-order) to bit 3.
- R5: `q` changes only at a rising clock edge; input changes between edges do not reach `q` while `clr_n` is high.
- R6: Driving `clr_n` low sets `q` to 0000 at once, without a clock edge.
- R7: While `clr_n` is low, a rising edge leaves `q` at 0000 whatever the select and data inputs are.
- R8: `par_in` affects `q` only under select 11; `ser_right_in` only under 01; `ser_left_in` only under 10.
- R9: Feeding `q[0]` back to `ser_right_in` under select 01 rotates 1000 to 0100, 0010, 0001 and back to 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; actions occur on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 keep, 01 shift right, 10 shift left, 11 load |
| ser_right_in | input | 1 | Serial bit entering bit 3 on a right shift |
| ser_left_in | input | 1 | Serial bit entering bit 0 on a left shift |
| par_in | input | WIDTH | Parallel load word, bit 3 high-order |
| q | output | WIDTH | Stored word, bit 3 high-order |

## Verification
The hardest case to reach is a clear that arrives between clock edges, or that is still held when an edge comes with an active shift or load select, because it must beat the operation the edge would otherwise perform. The stimulus asserts clear at random points in long random operation sequences, holds it across one or two edges with random select and data values, and also drops it in mid-cycle so the output is sampled before any edge could explain a change. Data and serial pins are randomised in every cycle, so modes that must ignore them are exercised throughout.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_DOWN = 2'b01,
        OP_UP   = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

endpackage

// File: rtl/ushift_decode.sv
module ushift_decode
    import ushift_pkg::*;
(
    input  logic [1:0] sel,
    output op_e        op
);

    always_comb begin
        unique case (sel)
            2'b00:   op = OP_KEEP;
            2'b01:   op = OP_DOWN;
            2'b10:   op = OP_UP;
            default: op = OP_LOAD;
        endcase
    end

endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
    import ushift_pkg::*;
(
    input  op_e  op,
    input  logic own,
    input  logic from_high,
    input  logic from_low,
    input  logic load_bit,
    output logic nxt
);

    always_comb begin
        unique case (op)
            OP_KEEP: nxt = own;
            OP_DOWN: nxt = from_high;
            OP_UP:   nxt = from_low;
            OP_LOAD: nxt = load_bit;
            default: nxt = own;
        endcase
    end

endmodule

// File: rtl/ushift4.sv
module ushift4
    import ushift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);

    localparam int MSB = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] nxt;

    ushift_decode u_decode (
        .sel (mode),
        .op  (op)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic hi_src;
        logic lo_src;

        if (i == MSB) begin : g_top
            assign hi_src = ser_right_in;
        end else begin : g_mid_hi
            assign hi_src = q[i+1];
        end

        if (i == 0) begin : g_bot
            assign lo_src = ser_left_in;
        end else begin : g_mid_lo
            assign lo_src = q[i-1];
        end

        ushift_cell u_cell (
            .op        (op),
            .own       (q[i]),
            .from_high (hi_src),
            .from_low  (lo_src),
            .load_bit  (par_in[i]),
            .nxt       (nxt[i])
        );
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    // R1
    a_r1_keep_stable: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> $stable(q));

    // R2
    a_r2_down_shift: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (q == {$past(ser_right_in), $past(q[MSB:1])}));

    // R3
    a_r3_up_shift: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (q == {$past(q[MSB-1:0]), $past(ser_left_in)}));

    // R4
    a_r4_load_copy: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (q == $past(par_in)));

    // R7
    a_r7_clear_wins: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

endmodule

// File: tb/test_ushift4.sv
module test_ushift4;

    localparam int W = 4;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         ser_right_in = 1'b0;
    logic         ser_left_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q;

    int    checks = 0;
    int    failures = 0;
    logic [W-1:0] model = '0;
    item_t sb[$];
    bit    done = 0;

    always #4 clk = ~clk;

    ushift4 #(.WIDTH(W)) i_ushift4 (
        .clk          (clk),
        .clr_n        (clr_n),
        .mode         (mode),
        .ser_right_in (ser_right_in),
        .ser_left_in  (ser_left_in),
        .par_in       (par_in),
        .q            (q)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: q=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R1 R8";
            2'b01:   return "R2 R8";
            2'b10:   return "R3 R8";
            default: return "R4 R8";
        endcase
    endfunction

    // driver: drives one cycle at the falling edge and queues the expected word
    task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                        input logic [W-1:0] p, input logic c, input string tag_in);
        item_t it;
        @(negedge clk);
        mode = m; ser_right_in = sr; ser_left_in = sl; par_in = p; clr_n = c;
        if (!c) begin
            model = '0;
        end else begin
            case (m)
                2'b00:   model = model;
                2'b01:   model = {sr, model[W-1:1]};
                2'b10:   model = {model[W-2:0], sl};
                default: model = p;
            endcase
        end
        it.exp = model;
        it.tag = (tag_in == "") ? (c ? mode_tag(m) : "R7") : tag_in;
        sb.push_back(it);
    endtask

    // monitor: compares after each rising edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(q, it.exp, it.tag);
        end
    end

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog: q=%b expected completion", q);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] ring [4];
        ring[0] = 4'b0100; ring[1] = 4'b0010; ring[2] = 4'b0001; ring[3] = 4'b1000;

        #2;
        check(q, 4'b0000, "R6 reset");

        // directed modes
        step(2'b11, 1'b0, 1'b0, 4'b1010, 1'b1, "R4");
        step(2'b00, 1'b1, 1'b1, 4'b0101, 1'b1, "R1 R8");
        step(2'b01, 1'b1, 1'b0, 4'b1111, 1'b1, "R2 R8");
        step(2'b10, 1'b0, 1'b1, 4'b0000, 1'b1, "R3 R8");
        step(2'b10, 1'b1, 1'b0, 4'b1111, 1'b1, "R3 R8");

        // R5: change inputs between edges, q must hold
        @(posedge clk);
        #3;
        mode = 2'b11; par_in = ~model; ser_right_in = ~ser_right_in;
        #0.5;
        check(q, model, "R5");

        // R6: clear in mid-cycle, no edge
        @(posedge clk);
        #3;
        clr_n = 1'b0;
        #0.5;
        model = '0;
        check(q, 4'b0000, "R6");

        // R7: edges with clear held and active operations
        step(2'b11, 1'b1, 1'b1, 4'b1111, 1'b0, "R7");
        step(2'b01, 1'b1, 1'b1, 4'b1111, 1'b0, "R7");

        // R9: rotation through external feedback
        step(2'b11, 1'b0, 1'b0, 4'b1000, 1'b1, "R4");
        for (int k = 0; k < 4; k++) begin
            item_t it;
            @(negedge clk);
            mode = 2'b01; ser_right_in = model[0]; ser_left_in = $urandom_range(1);
            par_in = 4'($urandom); clr_n = 1'b1;
            model = {model[0], model[W-1:1]};
            it.exp = ring[k];
            it.tag = "R9";
            sb.push_back(it);
        end

        // random sequence with clears in the middle
        for (int n = 0; n < 400; n++) begin
            logic c;
            c = ($urandom_range(19) != 0);
            step(2'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), c, "");
        end
        step(2'b00, 1'b0, 1'b0, 4'b0000, 1'b1, "");

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule